// File: doc/BRIEF.md
# Vibration-Driver Control Register Target on I2C

This block is the control port of a vibration-motor driver. It is an I2C target with a 7-bit address. Through it a host processor reads and writes a small bank of 8-bit control registers. The registers feed the drive logic as one flat vector, `reg_image`.

The block oversamples SCL and SDA with the system clock. Each line goes through a two-flop synchronizer and then a glitch filter. The block then detects START, repeated START, STOP and SCL edges. It pulls SDA low through an open-drain enable, and only for an ACK or a zero data bit.

A write carries a register index and then data bytes. The bytes go to successive indices. They sit in a staging copy and reach the live registers only when STOP arrives. A read is a write that carries only the index, then a repeated START with the read bit, then bytes from that index onward. A standby input, active low, forces every register to its default and silences the target.

Top module: `vib_i2c_regbank`

States of the byte machine:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address and direction.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_INDEX` and `ST_INDEX_ACK`: take in the register index and acknowledge it.
- `ST_WDATA` and `ST_WDATA_ACK`: take in each data byte and acknowledge it.
- `ST_RDATA`: shifts a byte out.
- `ST_RDATA_ACK`: samples the host's ACK or NACK.

Transitions:
- START moves any state to `ST_ADDR`.
- STOP or standby moves any state to `ST_IDLE`.
- On the SCL fall after the eighth bit, a byte state moves to its ACK state. An address that does not match goes to `ST_IDLE` instead.
- On the SCL fall that ends an ACK slot:
  - `ST_ADDR_ACK` goes to `ST_INDEX` for a write or `ST_RDATA` for a read.
  - `ST_INDEX_ACK` and `ST_WDATA_ACK` go to `ST_WDATA`.
  - `ST_RDATA_ACK` goes to `ST_RDATA` if the host sent ACK, and to `ST_IDLE` if it sent NACK.

## Requirements
- R1: The target answers only to address 7'b1001001 (0x49), sent MSB first with the direction bit last (0 = write, 1 = read). Any other address receives no ACK (SDA stays released), and the bytes that follow up to the next START or STOP neither receive an ACK nor change any register.
- R2: In a write, the target pulls SDA low during the ACK slot of the address byte, of the index byte and of every data byte.
- R3: Successive data bytes of one write go to indices N, N+1, N+2 and so on. An increment from index NUM_REGS-1 (7 by default), or from any higher index, gives 0.
- R4: Written bytes reach `reg_image` only when STOP is detected, and `reg_image` does not change before then. A START or repeated START discards any staged bytes that were not yet committed.
- R5: A read that follows an index-only write and a repeated START returns the register at that index first, MSB first, on SDA.
- R6: Each ACK from the host during a read makes the target return the next index, with the same wrap rule as R3. After a NACK the target releases SDA until the next START.
- R7: While `standby_n` is low, every register holds its default and staged bytes are discarded. The default of register k is byte k of `DEFAULTS`, which is 64'h1E0A_4008_8005_3C10 by default. The target also does not acknowledge its address. The same defaults apply after `rst_n`.
- R8: A data byte sent to an index at or above NUM_REGS receives an ACK but changes no register. A read from such an index returns 0x00.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks (3 by default) is ignored.
- R10: A START seen in the middle of a byte restarts the byte machine, and the transaction that follows works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_n | input | 1 | Active-low standby; holds registers at their defaults |
| scl_i | input | 1 | SCL as seen on the bus |
| sda_i | input | 1 | SDA as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_image | output | 8*NUM_REGS | Live register values; register k is in bits 8k+7:8k |

## Verification
Every bus event reaches the byte machine about five system clocks after the pin changes: two synchronizer flops, the filter, and the edge register. So an ACK or a read bit appears on SDA about five clocks after the SCL fall that opens its slot. The bench holds each SCL phase for 8 clocks. It samples SDA one phase after SCL rises, which is 16 clocks after the fall. A committed write reaches `reg_image` one clock after STOP is detected. The bench therefore reads `reg_image` one full phase after its STOP, and it reads it before STOP to confirm that nothing has moved yet. Random write and read transactions are checked against a register model in the bench. The model applies the wrap rule and the rule for unimplemented indices.

// File: rtl/vib_i2c_pkg.sv
package vib_i2c_pkg;
    localparam int IDX_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_t;
endpackage

// File: rtl/vib_i2c_deglitch.sv
module vib_i2c_deglitch #(
    parameter int   FILT_LEN = 3,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic             sync1, sync2;
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= IDLE_VAL;
            sync2   <= IDLE_VAL;
            clean_o <= IDLE_VAL;
            run_cnt <= '0;
        end else begin
            sync1 <= raw_i;
            sync2 <= sync1;
            if (sync2 == clean_o) begin
                run_cnt <= '0;
            end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
                clean_o <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    // the filtered line may only move after FILT_LEN differing samples
    assert_filter_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_o != $past(clean_o)) |-> ($past(sync2) != $past(clean_o)));
endmodule

// File: rtl/vib_i2c_bank.sv
module vib_i2c_bank
    import vib_i2c_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  standby_n,
    input  logic                  stage_we,
    input  logic [IDX_W-1:0]      stage_idx,
    input  logic [7:0]            stage_data,
    input  logic                  commit,
    input  logic                  discard,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] reg_image
);
    logic [7:0] bank_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        logic [7:0] live_q, stage_q;
        logic       stage_vld;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q    <= DEFAULTS[g*8 +: 8];
                stage_q   <= '0;
                stage_vld <= 1'b0;
            end else if (!standby_n) begin
                live_q    <= DEFAULTS[g*8 +: 8];
                stage_vld <= 1'b0;
            end else if (commit) begin
                if (stage_vld) live_q <= stage_q;
                stage_vld <= 1'b0;
            end else if (discard) begin
                stage_vld <= 1'b0;
            end else if (stage_we && stage_idx == MY_IDX) begin
                stage_q   <= stage_data;
                stage_vld <= 1'b1;
            end
        end

        assign bank_q[g]            = live_q;
        assign reg_image[g*8 +: 8]  = live_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = bank_q[i];
        end
    end

    assert_commit_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby_n && !commit) |=> $stable(reg_image));
    assert_standby_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> (reg_image == DEFAULTS));
endmodule

// File: rtl/vib_i2c_fsm.sv
module vib_i2c_fsm
    import vib_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h49,
    parameter int         NUM_REGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_n,
    input  logic             scl_f,
    input  logic             sda_f,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_idx,
    output logic             stage_we,
    output logic [IDX_W-1:0] stage_idx,
    output logic [7:0]       stage_data,
    output logic             commit,
    output logic             discard,
    output logic             sda_oe
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    bus_state_t       state, state_nx;
    logic             scl_q, sda_q;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sh, tx_sh;
    logic [IDX_W-1:0] ptr;
    logic             rd_mode, host_ack;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p >= LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    wire start_ev  = scl_f & scl_q & sda_q & ~sda_f;
    wire stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
    wire scl_rise  = scl_f & ~scl_q;
    wire scl_fall  = ~scl_f & scl_q;
    wire byte_done = scl_fall && (bit_cnt == 4'd8);
    wire addr_hit  = (rx_sh[7:1] == DEV_ADDR);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!standby_n)    state_nx = ST_IDLE;
        else if (start_ev) state_nx = ST_ADDR;
        else if (stop_ev)  state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rd_mode ? ST_RDATA : ST_INDEX;
                ST_INDEX:     if (byte_done) state_nx = ST_INDEX_ACK;
                ST_INDEX_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_nx = host_ack ? ST_RDATA : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers: edge history, shifters, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '1;
            ptr      <= '0;
            rd_mode  <= 1'b0;
            host_ack <= 1'b0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            if (!standby_n || start_ev || stop_ev) begin
                bit_cnt <= '0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_INDEX, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_ADDR)  rd_mode <= rx_sh[0];
                            if (state == ST_INDEX) ptr <= rx_sh;
                            if (state == ST_WDATA) ptr <= step(ptr);
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall && rd_mode) begin
                        tx_sh <= rd_data;
                        ptr   <= step(ptr);
                    end
                    ST_RDATA: begin
                        if (scl_rise) bit_cnt <= bit_cnt + 1'b1;
                        else if (byte_done) bit_cnt <= '0;
                        else if (scl_fall) tx_sh <= {tx_sh[6:0], 1'b1};
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise) host_ack <= ~sda_f;
                        else if (scl_fall && host_ack) begin
                            tx_sh <= rd_data;
                            ptr   <= step(ptr);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        rd_idx     = ptr;
        stage_idx  = ptr;
        stage_data = rx_sh;
        stage_we   = standby_n && !start_ev && !stop_ev && (state == ST_WDATA) && byte_done;
        commit     = standby_n && stop_ev;
        discard    = start_ev;
        unique case (state)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                                sda_oe = ~tx_sh[7];
            default:                                 sda_oe = 1'b0;
        endcase
    end

    assert_bitcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);
    assert_drive_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
    assert_quiet_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !standby_n |=> !sda_oe);
    assert_miss_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_done && !addr_hit && standby_n && !start_ev && !stop_ev)
        |=> !sda_oe);
endmodule

// File: rtl/vib_i2c_regbank.sv
module vib_i2c_regbank
    import vib_i2c_pkg::*;
#(
    parameter int                    NUM_REGS = 8,
    parameter logic [6:0]            DEV_ADDR = 7'h49,
    parameter int                    FILT_LEN = 3,
    parameter logic [NUM_REGS*8-1:0] DEFAULTS = 64'h1E0A_4008_8005_3C10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  standby_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] reg_image
);
    logic             scl_f, sda_f;
    logic [7:0]       rd_data, stage_data;
    logic [IDX_W-1:0] rd_idx, stage_idx;
    logic             stage_we, commit, discard;

    vib_i2c_deglitch #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .clean_o(scl_f));
    vib_i2c_deglitch #(.FILT_LEN(FILT_LEN), .IDLE_VAL(1'b1)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .clean_o(sda_f));

    vib_i2c_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
        .scl_f(scl_f), .sda_f(sda_f),
        .rd_data(rd_data), .rd_idx(rd_idx),
        .stage_we(stage_we), .stage_idx(stage_idx), .stage_data(stage_data),
        .commit(commit), .discard(discard), .sda_oe(sda_oe));

    vib_i2c_bank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
        .stage_we(stage_we), .stage_idx(stage_idx), .stage_data(stage_data),
        .commit(commit), .discard(discard),
        .rd_idx(rd_idx), .rd_data(rd_data), .reg_image(reg_image));
endmodule

// File: tb/vib_i2c_regbank_test.sv
`timescale 1ns/1ps
module vib_i2c_regbank_test;
    localparam int          Q    = 8;
    localparam logic [63:0] DEFS = 64'h1E0A_4008_8005_3C10;
    localparam logic [6:0]  DEV  = 7'h49;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_n = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic [63:0] reg_image;
    wire         sda_bus = m_sda & ~sda_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];
    logic [7:0] wbuf  [8];
    logic [7:0] rbuf  [8];
    logic       all_ack;

    always #2.5 clk = ~clk;

    vib_i2c_regbank uut (
        .clk(clk), .rst_n(rst_n), .standby_n(standby_n),
        .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe), .reg_image(reg_image));

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_sim();
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return (p >= 8'd7) ? 8'd0 : p + 8'd1;
    endfunction
    function automatic logic [63:0] img();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction
    function automatic logic [7:0] mrd(input logic [7:0] p);
        return (p < 8'd8) ? model[p[2:0]] : 8'h00;
    endfunction

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask
    task automatic bus_start();
        m_sda = 1'b1; wait_q(1); m_scl = 1'b1; wait_q(1);
        m_sda = 1'b0; wait_q(1); m_scl = 1'b0; wait_q(1);
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; wait_q(1); m_scl = 1'b1; wait_q(1); m_sda = 1'b1; wait_q(1);
    endtask
    task automatic send_bit(input logic b, input bit glitch);
        m_sda = b; wait_q(1); m_scl = 1'b1;
        if (glitch) begin
            wait_q(1); m_scl = 1'b0; @(negedge clk); m_scl = 1'b1; wait_q(1);
        end else wait_q(2);
        m_scl = 1'b0; wait_q(1);
    endtask
    task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_bit);
        m_sda = 1'b1; wait_q(1); m_scl = 1'b1; wait_q(1);
        ack = (sda_bus == 1'b0);
        wait_q(1); m_scl = 1'b0; wait_q(1);
    endtask
    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(1); m_scl = 1'b1; wait_q(1); b[i] = sda_bus; wait_q(1); m_scl = 1'b0;
        end
        wait_q(1); m_sda = give_ack ? 1'b0 : 1'b1;
        wait_q(1); m_scl = 1'b1; wait_q(2); m_scl = 1'b0; m_sda = 1'b1; wait_q(1);
    endtask

    // write transaction without STOP; data from wbuf
    task automatic wr_body(input logic [6:0] dev, input logic [7:0] idx, input int n,
                           input int glitch_bit);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte({dev, 1'b0}, glitch_bit, a); all_ack &= a;
        send_byte(idx, -1, a); all_ack &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], -1, a); all_ack &= a;
        end
    endtask
    task automatic model_wr(input logic [7:0] idx, input int n);
        logic [7:0] p = idx;
        for (int k = 0; k < n; k++) begin
            if (p < 8'd8) model[p[2:0]] = wbuf[k];
            p = nxt(p);
        end
    endtask
    // index-only write, repeated START, read n bytes into rbuf
    task automatic rd_txn(input logic [7:0] idx, input int n);
        logic a;
        all_ack = 1'b1;
        bus_start();
        send_byte({DEV, 1'b0}, -1, a); all_ack &= a;
        send_byte(idx, -1, a); all_ack &= a;
        bus_start();
        send_byte({DEV, 1'b1}, -1, a); all_ack &= a;
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask
    task automatic check_read(input string req, input logic [7:0] idx, input int n);
        logic [7:0] p = idx;
        chk(req, {63'd0, all_ack}, 64'd1);
        for (int k = 0; k < n; k++) begin
            chk(req, {56'd0, rbuf[k]}, {56'd0, mrd(p)});
            p = nxt(p);
        end
    endtask

    initial begin
        logic a;
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) model[i] = DEFS[i*8 +: 8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state (R7)
        chk("R7 reset image", reg_image, DEFS);
        chk("R7 reset sda released", {63'd0, sda_oe}, 64'd0);

        // wrong address: no ACK, nothing written (R1)
        wbuf[0] = 8'hAA;
        bus_start();
        send_byte({7'h48, 1'b0}, -1, a);
        chk("R1 foreign address no ACK", {63'd0, a}, 64'd0);
        send_byte(8'h01, -1, a);
        chk("R1 following byte no ACK", {63'd0, a}, 64'd0);
        bus_stop(); wait_q(1);
        chk("R1 image untouched", reg_image, img());

        // burst write with wrap, staged until STOP (R2 R3 R4)
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_body(DEV, 8'd6, 4, -1);
        chk("R2 all bytes ACKed", {63'd0, all_ack}, 64'd1);
        wait_q(1);
        chk("R4 no change before STOP", reg_image, img());
        bus_stop(); wait_q(1);
        model_wr(8'd6, 4);
        chk("R3 wrap write 6,7,0,1", reg_image, img());

        // unimplemented index: ACKed, ignored, reads zero (R8)
        wbuf[0] = 8'h5A;
        wr_body(DEV, 8'h40, 1, -1);
        chk("R8 unimplemented write ACKed", {63'd0, all_ack}, 64'd1);
        bus_stop(); wait_q(1);
        chk("R8 unimplemented write ignored", reg_image, img());
        rd_txn(8'd9, 1);
        check_read("R8 unimplemented read", 8'd9, 1);

        // repeated START discards staged bytes (R4), read continues at pointer
        wbuf[0] = 8'hC3;
        wr_body(DEV, 8'd2, 1, -1);
        bus_start();
        send_byte({DEV, 1'b1}, -1, a);
        chk("R5 read address ACK", {63'd0, a}, 64'd1);
        recv_byte(1'b0, rbuf[0]);
        chk("R5 read at advanced pointer", {56'd0, rbuf[0]}, {56'd0, mrd(8'd3)});
        bus_stop(); wait_q(1);
        chk("R4 discard on repeated START", reg_image, img());

        // read with wrap and NACK release (R5 R6)
        rd_txn(8'd7, 3);
        check_read("R6 read wrap", 8'd7, 3);
        chk("R6 released after NACK", {63'd0, sda_oe}, 64'd0);

        // glitch on SCL inside address byte (R9)
        wbuf[0] = 8'h9D;
        wr_body(DEV, 8'd4, 1, 3);
        bus_stop(); wait_q(1);
        model_wr(8'd4, 1);
        chk("R9 glitch ignored ACK", {63'd0, all_ack}, 64'd1);
        chk("R9 glitch ignored data", reg_image, img());

        // START inside a byte restarts the machine (R10)
        bus_start();
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        wbuf[0] = 8'h7E;
        wr_body(DEV, 8'd5, 1, -1);
        bus_stop(); wait_q(1);
        model_wr(8'd5, 1);
        chk("R10 restart ACK", {63'd0, all_ack}, 64'd1);
        chk("R10 restart write", reg_image, img());

        // random mix against the model (R2 R3 R5 R6 R8)
        for (int t = 0; t < 14; t++) begin
            logic [7:0] idx = 8'($urandom % 10);
            int n = 1 + int'($urandom % 4);
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                wr_body(DEV, idx, n, -1);
                chk("R2 random write ACK", {63'd0, all_ack}, 64'd1);
                bus_stop(); wait_q(1);
                model_wr(idx, n);
                chk("R3 random write image", reg_image, img());
            end else begin
                rd_txn(idx, n);
                check_read("R6 random read", idx, n);
            end
        end

        // standby wipes registers and silences target (R7)
        standby_n = 1'b0;
        wait_q(1);
        for (int i = 0; i < 8; i++) model[i] = DEFS[i*8 +: 8];
        chk("R7 standby defaults", reg_image, DEFS);
        wbuf[0] = 8'hFF;
        wr_body(DEV, 8'd0, 1, -1);
        chk("R7 no ACK in standby", {63'd0, all_ack}, 64'd0);
        bus_stop(); wait_q(1);
        chk("R7 standby write ignored", reg_image, DEFS);
        standby_n = 1'b1;
        wait_q(2);
        chk("R7 defaults after standby", reg_image, DEFS);
        wbuf[0] = 8'h42;
        wr_body(DEV, 8'd1, 1, -1);
        bus_stop(); wait_q(1);
        model_wr(8'd1, 1);
        chk("R7 writable after standby", reg_image, img());

        finish_sim();
    end
endmodule